// File: doc/BRIEF.md
# Cyclic Process-Data Exchange Unit

This block connects the telegram engine of a real-time Ethernet slave to sixteen digital outputs and sixteen digital inputs. The telegram engine writes the two output payload bytes into a staging area as it extracts them and then marks the connection complete for the current cycle. A commit copies the staged bytes into a receive buffer and flags it as fresh. The output pins change only on a cycle-synchronous IO trigger, so every output moves together at a fixed point in the bus cycle.

A configuration input selects the trigger. When an unscheduled channel is configured, the trigger is the start of that channel. Otherwise it is the start of the first master-data telegram of the cycle. The same trigger latches the synchronized input pins into a send buffer. The telegram engine reads that buffer byte by byte when it builds the next acknowledge telegram. The buffer does not change between triggers, so the word it reads is always consistent.

When the communication phase falls to phase 0 or to the non-real-time state, the outputs go to all low and any pending received word is discarded.

Top module: `pdx_unit`

## Requirements
- R1: After reset the output pins are all low and the acknowledge read data is all zero.
- R2: Output byte mapping: a byte written with index 0 drives channels 1 to 8 on do_pins[7:0], with channel 1 in bit 0. A byte written with index 1 drives channels 9 to 16 on do_pins[15:8], with channel 9 in bit 8.
- R3: Staged and committed output bytes leave do_pins unchanged until an IO trigger occurs. The pins take the committed word in the clock after the trigger.
- R4: When cfg_uc_en is 1, only ev_uc_start acts as the IO trigger. When cfg_uc_en is 0, only ev_mdt0_start acts as the trigger. The other event has no effect on the outputs or on the send buffer.
- R5: A trigger with no commit since the previous trigger leaves do_pins at their previous value.
- R6: A commit in the same clock as a trigger is not used by that trigger. The trigger drives the word committed earlier, or holds the pins if there is none. The next trigger drives the newly committed word.
- R7: Byte writes made after a commit do not change the word that the next trigger drives. Only a later commit replaces it.
- R8: While comm_phase is 0 or 7, do_pins are all low from the next clock on and triggers are ignored. A commit made before or during this state is discarded, so after the phase returns, a trigger with no new commit keeps the pins low.
- R9: At a trigger the send buffer captures di_pins as they stood at least SYNC_STAGES clocks earlier. tx_sel 0 returns channels 1 to 8 with channel 1 in bit 0, and tx_sel 1 returns channels 9 to 16 with channel 9 in bit 0.
- R10: Between triggers the acknowledge read data stays stable whatever di_pins do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_uc_en | input | 1 | 1: trigger on unscheduled channel start; 0: trigger on first master-data telegram start |
| ev_uc_start | input | 1 | Pulse at start of the unscheduled channel |
| ev_mdt0_start | input | 1 | Pulse at start of the first master-data telegram |
| comm_phase | input | 3 | Communication phase: 0 = phase 0, 1..4 = phases 1..4, 7 = non-real-time |
| rx_we | input | 1 | Output payload byte write strobe |
| rx_sel | input | 1 | Payload byte index (0 = channels 1..8, 1 = channels 9..16) |
| rx_data | input | 8 | Payload byte value |
| rx_commit | input | 1 | Connection received and valid for this cycle |
| di_pins | input | 16 | Digital inputs, asynchronous |
| tx_sel | input | 1 | Acknowledge byte index to read |
| tx_data | output | 8 | Selected send-buffer byte |
| do_pins | output | 16 | Digital outputs |

## Verification
The bench targets a commit that lands in the same clock as a trigger. A design without the double buffer would drive the new word one trigger early. It also writes staging bytes after a commit: a single-buffered design would leak those bytes into the next update. Triggers with no fresh commit and pulses of the unselected event check that the pins hold, since a design that updates on every pulse, or on either event, would change them. A commit made before a phase drop is followed by a trigger after the phase returns; a design that keeps the stale word would drive it again instead of staying low. The send buffer is read while di_pins toggle, so an implementation that reads the pins directly would show tearing.

// File: rtl/pdx_pkg.sv
package pdx_pkg;

    localparam int PD_BYTES   = 2;
    localparam int PD_WIDTH   = 8 * PD_BYTES;
    localparam int PHASE_W    = 3;

    typedef enum logic [PHASE_W-1:0] {
        PH_ZERO  = 3'd0,
        PH_ONE   = 3'd1,
        PH_TWO   = 3'd2,
        PH_THREE = 3'd3,
        PH_FOUR  = 3'd4,
        PH_NRT   = 3'd7
    } comm_phase_e;

    typedef struct packed {
        logic       we;
        logic       sel;
        logic [7:0] data;
        logic       commit;
    } rx_req_t;

    function automatic logic phase_is_fallback(input logic [PHASE_W-1:0] ph);
        return (ph == PH_ZERO) || (ph == PH_NRT);
    endfunction

endpackage

// File: rtl/pdx_trig_sel.sv
module pdx_trig_sel (
    input  logic clk,
    input  logic rst,
    input  logic cfg_uc_en,
    input  logic ev_uc_start,
    input  logic ev_mdt0_start,
    output logic io_trig
);
    always_comb begin
        if (cfg_uc_en) io_trig = ev_uc_start;
        else           io_trig = ev_mdt0_start;
    end

    // R4: an unselected event never produces a trigger
    assert_unselected_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_uc_en && !ev_uc_start) || (!cfg_uc_en && !ev_mdt0_start) |-> !io_trig);
endmodule

// File: rtl/pdx_rx_buf.sv
module pdx_rx_buf
    import pdx_pkg::*;
#(
    parameter int BYTES = PD_BYTES
) (
    input  logic               clk,
    input  logic               rst,
    input  rx_req_t            req,
    input  logic               io_trig,
    input  logic               fallback,
    output logic [8*BYTES-1:0] held_word,
    output logic               held_valid
);
    localparam int W = 8 * BYTES;

    logic [BYTES-1:0][7:0] stage_q;
    logic [W-1:0]          hold_q;
    logic                  valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else if (req.we) begin
            for (int b = 0; b < BYTES; b++) begin
                if (int'(req.sel) == b) stage_q[b] <= req.data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            valid_q <= 1'b0;
        end else if (fallback) begin
            valid_q <= 1'b0;
        end else if (req.commit) begin
            hold_q  <= stage_q;
            valid_q <= 1'b1;
        end else if (io_trig) begin
            valid_q <= 1'b0;
        end
    end

    assign held_word  = hold_q;
    assign held_valid = valid_q;

    // R6: a commit always leaves a fresh word, even if a trigger came at the same time
    assert_commit_sets_valid_R6: assert property (@(posedge clk) disable iff (rst)
        req.commit && !fallback |=> held_valid);

    // R5: a trigger without a commit consumes the fresh word
    assert_trig_consumes_R5: assert property (@(posedge clk) disable iff (rst)
        io_trig && !req.commit |=> !held_valid);

    // R7: the held word changes only through a commit
    assert_hold_only_on_commit_R7: assert property (@(posedge clk) disable iff (rst)
        !req.commit |=> $stable(held_word));
endmodule

// File: rtl/pdx_out_stage.sv
module pdx_out_stage #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         io_trig,
    input  logic         fallback,
    input  logic [W-1:0] held_word,
    input  logic         held_valid,
    output logic [W-1:0] do_pins
);
    logic [W-1:0] out_q;

    always_ff @(posedge clk) begin
        if (rst)                        out_q <= '0;
        else if (fallback)              out_q <= '0;
        else if (io_trig && held_valid) out_q <= held_word;
    end

    assign do_pins = out_q;

    // R8: outputs are low in the clock after a fallback phase is seen
    assert_fallback_low_R8: assert property (@(posedge clk) disable iff (rst)
        fallback |=> (do_pins == '0));

    // R3: without a trigger or a fallback the pins hold
    assert_hold_without_trig_R3: assert property (@(posedge clk) disable iff (rst)
        !io_trig && !fallback |=> $stable(do_pins));
endmodule

// File: rtl/pdx_in_capture.sv
module pdx_in_capture #(
    parameter int BYTES       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [8*BYTES-1:0] di_pins,
    input  logic               io_trig,
    input  logic [((BYTES > 1) ? $clog2(BYTES) : 1)-1:0] tx_sel,
    output logic [7:0]         tx_data
);
    localparam int W = 8 * BYTES;

    logic [W-1:0] sync_out;
    logic [W-1:0] snd_q;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : gen_sync
        logic [W-1:0] q;
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= di_pins;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= gen_sync[g-1].q;
            end
        end
    end

    assign sync_out = gen_sync[SYNC_STAGES-1].q;

    always_ff @(posedge clk) begin
        if (rst)          snd_q <= '0;
        else if (io_trig) snd_q <= sync_out;
    end

    assign tx_data = snd_q[int'(tx_sel)*8 +: 8];

    // R10: the send buffer never moves between triggers
    assert_send_stable_R10: assert property (@(posedge clk) disable iff (rst)
        !io_trig |=> $stable(snd_q));
endmodule

// File: rtl/pdx_unit.sv
module pdx_unit
    import pdx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_uc_en,
    input  logic                ev_uc_start,
    input  logic                ev_mdt0_start,
    input  logic [PHASE_W-1:0]  comm_phase,
    input  logic                rx_we,
    input  logic                rx_sel,
    input  logic [7:0]          rx_data,
    input  logic                rx_commit,
    input  logic [PD_WIDTH-1:0] di_pins,
    input  logic                tx_sel,
    output logic [7:0]          tx_data,
    output logic [PD_WIDTH-1:0] do_pins
);
    logic                io_trig;
    logic                fallback;
    logic [PD_WIDTH-1:0] held_word;
    logic                held_valid;
    rx_req_t             req;

    assign fallback = phase_is_fallback(comm_phase);
    assign req      = '{we: rx_we, sel: rx_sel, data: rx_data, commit: rx_commit};

    pdx_trig_sel u_trig (
        .clk(clk), .rst(rst), .cfg_uc_en(cfg_uc_en),
        .ev_uc_start(ev_uc_start), .ev_mdt0_start(ev_mdt0_start),
        .io_trig(io_trig)
    );

    pdx_rx_buf #(.BYTES(PD_BYTES)) u_rx (
        .clk(clk), .rst(rst), .req(req), .io_trig(io_trig),
        .fallback(fallback), .held_word(held_word), .held_valid(held_valid)
    );

    pdx_out_stage #(.W(PD_WIDTH)) u_out (
        .clk(clk), .rst(rst), .io_trig(io_trig), .fallback(fallback),
        .held_word(held_word), .held_valid(held_valid), .do_pins(do_pins)
    );

    pdx_in_capture #(.BYTES(PD_BYTES), .SYNC_STAGES(SYNC_STAGES)) u_in (
        .clk(clk), .rst(rst), .di_pins(di_pins), .io_trig(io_trig),
        .tx_sel(tx_sel), .tx_data(tx_data)
    );
endmodule

// File: tb/pdx_unit_tb_top.sv
module pdx_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_uc_en = 1'b1;
    logic        ev_uc_start = 1'b0;
    logic        ev_mdt0_start = 1'b0;
    logic [2:0]  comm_phase = 3'd4;
    logic        rx_we = 1'b0;
    logic        rx_sel = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_commit = 1'b0;
    logic [15:0] di_pins = 16'h0000;
    logic        tx_sel = 1'b0;
    logic [7:0]  tx_data;
    logic [15:0] do_pins;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    pdx_unit dut_i (
        .clk(clk), .rst(rst), .cfg_uc_en(cfg_uc_en),
        .ev_uc_start(ev_uc_start), .ev_mdt0_start(ev_mdt0_start),
        .comm_phase(comm_phase), .rx_we(rx_we), .rx_sel(rx_sel),
        .rx_data(rx_data), .rx_commit(rx_commit), .di_pins(di_pins),
        .tx_sel(tx_sel), .tx_data(tx_data), .do_pins(do_pins)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_byte(input logic sel, input logic [7:0] d);
        @(negedge clk); rx_we = 1'b1; rx_sel = sel; rx_data = d;
        @(negedge clk); rx_we = 1'b0;
    endtask

    task automatic commit();
        @(negedge clk); rx_commit = 1'b1;
        @(negedge clk); rx_commit = 1'b0;
    endtask

    task automatic fire(input logic uc);
        @(negedge clk); if (uc) ev_uc_start = 1'b1; else ev_mdt0_start = 1'b1;
        @(negedge clk); ev_uc_start = 1'b0; ev_mdt0_start = 1'b0;
    endtask

    task automatic read_tx(output logic [15:0] w);
        tx_sel = 1'b0; #1; w[7:0] = tx_data;
        tx_sel = 1'b1; #1; w[15:8] = tx_data;
        tx_sel = 1'b0;
    endtask

    task automatic load_word(input logic [15:0] w);
        wr_byte(1'b0, w[7:0]);
        wr_byte(1'b1, w[15:8]);
        commit();
    endtask

    task automatic t_reset();
        logic [15:0] w;
        chk("R1 outputs after reset", do_pins, 16'h0000);
        read_tx(w);
        chk("R1 send buffer after reset", w, 16'h0000);
    endtask

    task automatic t_mapping();
        cfg_uc_en = 1'b1;
        load_word(16'h2001);
        idle(2);
        chk("R3 no change before trigger", do_pins, 16'h0000);
        fire(1'b1);
        chk("R2 byte0=0x01 byte1=0x20 mapping", do_pins, 16'h2001);
        load_word(16'h0080);
        fire(1'b1);
        chk("R2 channel 8 is bit 7", do_pins, 16'h0080);
    endtask

    task automatic t_trigger_select();
        logic [15:0] w;
        cfg_uc_en = 1'b1;
        load_word(16'h1234);
        fire(1'b0);
        chk("R4 first-telegram event ignored when uc selected", do_pins, 16'h0080);
        fire(1'b1);
        chk("R4 uc event triggers", do_pins, 16'h1234);
        cfg_uc_en = 1'b0;
        load_word(16'h5678);
        di_pins = 16'hBEEF;
        idle(4);
        fire(1'b1);
        chk("R4 uc event ignored when not selected", do_pins, 16'h1234);
        read_tx(w);
        chk("R4 uc event ignored by send buffer", w, 16'h0000);
        fire(1'b0);
        chk("R4 first-telegram event triggers", do_pins, 16'h5678);
        read_tx(w);
        chk("R9 send buffer captures inputs", w, 16'hBEEF);
        cfg_uc_en = 1'b1;
    endtask

    task automatic t_no_commit();
        fire(1'b1);
        chk("R5 hold without commit", do_pins, 16'h5678);
    endtask

    task automatic t_collision();
        wr_byte(1'b0, 8'hAA);
        wr_byte(1'b1, 8'h55);
        @(negedge clk); rx_commit = 1'b1; ev_uc_start = 1'b1;
        @(negedge clk); rx_commit = 1'b0; ev_uc_start = 1'b0;
        chk("R6 commit with trigger not taken", do_pins, 16'h5678);
        fire(1'b1);
        chk("R6 next trigger takes it", do_pins, 16'h55AA);
    endtask

    task automatic t_double_buffer();
        load_word(16'h0F0F);
        wr_byte(1'b0, 8'hFF);
        wr_byte(1'b1, 8'hFF);
        fire(1'b1);
        chk("R7 staging writes after commit not driven", do_pins, 16'h0F0F);
        commit();
        fire(1'b1);
        chk("R7 later commit takes staging", do_pins, 16'hFFFF);
    endtask

    task automatic t_fallback();
        load_word(16'hC3C3);
        @(negedge clk); comm_phase = 3'd0;
        @(negedge clk);
        chk("R8 phase 0 drives low", do_pins, 16'h0000);
        fire(1'b1);
        chk("R8 trigger ignored in fallback", do_pins, 16'h0000);
        comm_phase = 3'd4;
        fire(1'b1);
        chk("R8 stale commit discarded", do_pins, 16'h0000);
        load_word(16'h0101);
        fire(1'b1);
        chk("R8 recovery with new commit", do_pins, 16'h0101);
        @(negedge clk); comm_phase = 3'd7;
        @(negedge clk);
        chk("R8 non-real-time drives low", do_pins, 16'h0000);
        comm_phase = 3'd4;
    endtask

    task automatic t_inputs();
        logic [15:0] w;
        di_pins = 16'h8001;
        idle(4);
        fire(1'b1);
        read_tx(w);
        chk("R9 channel 1 bit0 and channel 16", w, 16'h8001);
        tx_sel = 1'b1; #1;
        chk("R9 byte1 channels 9-16", {8'h00, tx_data}, 16'h0080);
        tx_sel = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); di_pins = 16'h1111 * i[15:0];
            read_tx(w);
            chk("R10 send buffer stable between triggers", w, 16'h8001);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired: actual running expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_mapping();
        t_trigger_select();
        t_no_commit();
        t_collision();
        t_double_buffer();
        t_fallback();
        t_inputs();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule